// File: doc/BRIEF.md
# System Control Coprocessor Register Bank

This block is the register file that a processor core reaches with its move-to-coprocessor and move-from-coprocessor operations. Every access carries a four-field selector (primary register number, first opcode, secondary register number, second opcode). It also carries a read strobe, a write strobe, 32-bit write data and a flag saying whether the core is in a privileged mode. The bank answers with read data and a flag that marks an access as undefined.

The bank holds three kinds of entry:
- Constant identification words, which cannot be written.
- Writable state with fixed reset values: control, translation base, domain, fault, lockdown, remap, context, thread ID and performance registers.
- A set of write-only command selectors for cache, TLB and barrier operations. The bank latches these writes and does no cache or translation work itself.

Privilege is checked per register. Most entries need a privileged mode. One thread register is open to user code for both read and write. A second thread register can be read by user code but written only when privileged. The two barriers and the prefetch flush take writes from any mode. Reads follow the selector combinationally. Writes land on the rising clock edge.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset these registers read as follows: control (1,0,0,0) 0x00054078, auxiliary control (1,0,0,1) 0x0000000F, data cache lockdown (9,0,0,0) 0xFFFFFFF0, primary remap (10,0,2,0) 0x00098AA4, normal remap (10,0,2,1) 0x44E048E0. All other writable registers read zero after reset.
- R2: Identification selectors at primary 0, opcode1 0, crm 0 to 2 return constants in a privileged read. The main ID (0,0,0,0) is 0x410FB024, the TLB type (0,0,0,3) is 0x00000800 and (0,0,2,4) is 0x00000141. A write to any of them is ignored and raises the undefined flag.
- R3: A privileged write to a writable register takes effect at the rising clock edge. A read of the same selector in the same cycle returns the value held before that edge.
- R4: A user-mode access to a privileged-only register reads zero, leaves the register unchanged and raises the undefined flag.
- R5: The thread register (13,0,0,2) can be read and written from any mode without raising the undefined flag.
- R6: The thread register (13,0,0,3) can be read from any mode. A user-mode write to it is ignored and raises the undefined flag, while a privileged write is accepted.
- R7: Writes to the barrier and prefetch flush selectors (7,0,10,4), (7,0,10,5) and (7,0,5,4) are accepted from any mode with the undefined flag low. A read of any command selector returns zero and raises the undefined flag.
- R8: Cache and TLB command selectors, for example (8,0,7,0) and (7,0,5,0), accept privileged writes with the undefined flag low. A user-mode write to them raises the undefined flag.
- R9: A read of an unmapped selector, for example (4,0,0,0), returns zero and raises the undefined flag. A write to an unmapped selector, for example (1,1,0,0), raises the flag and changes no register.
- R10: In a cycle with neither strobe high, the read data is zero and the undefined flag is low. The undefined flag is high only in a cycle that carries a strobe.
- R11: The performance registers at (15,0,12,op2) with op2 0 to 3 are four separate writable words that read back what was last written to each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_rd | input | 1 | Read strobe for the current selector |
| acc_wr | input | 1 | Write strobe for the current selector |
| sel_crn | input | 4 | Primary register number |
| sel_op1 | input | 3 | First opcode field |
| sel_crm | input | 4 | Secondary register number |
| sel_op2 | input | 3 | Second opcode field |
| wr_data | input | 32 | Write data |
| priv | input | 1 | High when the access comes from a privileged mode |
| rd_data | output | 32 | Read data, zero unless a permitted read is made |
| undef_acc | output | 1 | High in a cycle whose access is unmapped or refused |

## Verification
A read and a write can hit the same register in the same cycle. The bench provokes this by raising both strobes on the control register and on the user thread register. It expects the old value on the read port in that cycle and the new value on a read in the next cycle. A privilege refusal and an accepted operation can also share a cycle, so the bench raises both strobes on the user read-only thread register from user mode. There the read must be accepted and the write refused, with the flag high and the stored value kept.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   localparam int DW     = 32;
   localparam int NUM_RW = 29;
   localparam int IDX_W  = $clog2(NUM_RW);

   typedef struct packed {
      logic [3:0] crn;
      logic [2:0] op1;
      logic [3:0] crm;
      logic [2:0] op2;
   } sel_t;

   typedef enum logic [1:0] {K_NONE, K_ID, K_RW, K_CMD} kind_e;

   typedef struct packed {
      kind_e            kind;
      logic [IDX_W-1:0] idx;
      logic             usr_rd;
      logic             usr_wr;
   } hit_t;

   function automatic sel_t mk(input int crn, input int op1, input int crm, input int op2);
      sel_t s;
      s.crn = 4'(crn);
      s.op1 = 3'(op1);
      s.crm = 4'(crm);
      s.op2 = 3'(op2);
      return s;
   endfunction

   function automatic hit_t rw_hit(input int idx, input logic ur, input logic uw);
      hit_t h;
      h.kind   = K_RW;
      h.idx    = IDX_W'(idx);
      h.usr_rd = ur;
      h.usr_wr = uw;
      return h;
   endfunction

   // Writable and command selector lookup (identification is decoded elsewhere)
   function automatic hit_t lookup(input sel_t s);
      hit_t h;
      h = '{kind: K_NONE, idx: '0, usr_rd: 1'b0, usr_wr: 1'b0};
      case (s)
         mk(1,0,0,0):   h = rw_hit(0,  1'b0, 1'b0);
         mk(1,0,0,1):   h = rw_hit(1,  1'b0, 1'b0);
         mk(1,0,0,2):   h = rw_hit(2,  1'b0, 1'b0);
         mk(2,0,0,0):   h = rw_hit(3,  1'b0, 1'b0);
         mk(2,0,0,1):   h = rw_hit(4,  1'b0, 1'b0);
         mk(2,0,0,2):   h = rw_hit(5,  1'b0, 1'b0);
         mk(3,0,0,0):   h = rw_hit(6,  1'b0, 1'b0);
         mk(5,0,0,0):   h = rw_hit(7,  1'b0, 1'b0);
         mk(5,0,0,1):   h = rw_hit(8,  1'b0, 1'b0);
         mk(6,0,0,0):   h = rw_hit(9,  1'b0, 1'b0);
         mk(6,0,0,1):   h = rw_hit(10, 1'b0, 1'b0);
         mk(7,0,4,0):   h = rw_hit(11, 1'b0, 1'b0);
         mk(9,0,0,0):   h = rw_hit(12, 1'b0, 1'b0);
         mk(10,0,0,0):  h = rw_hit(13, 1'b0, 1'b0);
         mk(10,0,2,0):  h = rw_hit(14, 1'b0, 1'b0);
         mk(10,0,2,1):  h = rw_hit(15, 1'b0, 1'b0);
         mk(13,0,0,0):  h = rw_hit(16, 1'b0, 1'b0);
         mk(13,0,0,1):  h = rw_hit(17, 1'b0, 1'b0);
         mk(13,0,0,2):  h = rw_hit(18, 1'b1, 1'b1);
         mk(13,0,0,3):  h = rw_hit(19, 1'b1, 1'b0);
         mk(13,0,0,4):  h = rw_hit(20, 1'b0, 1'b0);
         mk(15,0,12,0): h = rw_hit(21, 1'b0, 1'b0);
         mk(15,0,12,1): h = rw_hit(22, 1'b0, 1'b0);
         mk(15,0,12,2): h = rw_hit(23, 1'b0, 1'b0);
         mk(15,0,12,3): h = rw_hit(24, 1'b0, 1'b0);
         mk(15,5,5,2):  h = rw_hit(25, 1'b0, 1'b0);
         mk(15,5,6,2):  h = rw_hit(26, 1'b0, 1'b0);
         mk(15,5,7,2):  h = rw_hit(27, 1'b0, 1'b0);
         mk(15,7,1,0):  h = rw_hit(28, 1'b0, 1'b0);
         default: begin
            if (s.crn == 4'd7 && s.op1 == 3'd0) begin
               case (s.crm)
                  4'd0:  if (s.op2 == 3'd4) h.kind = K_CMD;
                  4'd5:  if (s.op2 != 3'd3 && s.op2 != 3'd5) h.kind = K_CMD;
                  4'd6:  if (s.op2 <= 3'd2) h.kind = K_CMD;
                  4'd7:  if (s.op2 == 3'd0) h.kind = K_CMD;
                  4'd10: if (s.op2 <= 3'd2 || s.op2 == 3'd4 || s.op2 == 3'd5) h.kind = K_CMD;
                  4'd14: if (s.op2 <= 3'd2) h.kind = K_CMD;
                  default: h.kind = K_NONE;
               endcase
               // barriers and prefetch flush are open to user mode
               if ((s.crm == 4'd10 && (s.op2 == 3'd4 || s.op2 == 3'd5)) ||
                   (s.crm == 4'd5 && s.op2 == 3'd4))
                  h.usr_wr = 1'b1;
            end else if (s.crn == 4'd8 && s.op1 == 3'd0 &&
                         s.crm >= 4'd5 && s.crm <= 4'd7 && s.op2 <= 3'd3) begin
               h.kind = K_CMD;
            end else if (s.crn == 4'd15 && s.op1 == 3'd5 && s.crm == 4'd4 &&
                         (s.op2 == 3'd2 || s.op2 == 3'd4)) begin
               h.kind = K_CMD;
            end
         end
      endcase
      return h;
   endfunction

   function automatic logic [DW-1:0] rw_reset(input int idx);
      case (idx)
         0:       return 32'h0005_4078;
         1:       return 32'h0000_000F;
         12:      return 32'hFFFF_FFF0;
         14:      return 32'h0009_8AA4;
         15:      return 32'h44E0_48E0;
         default: return '0;
      endcase
   endfunction

   function automatic logic [NUM_RW*DW-1:0] rw_reset_vec();
      logic [NUM_RW*DW-1:0] v;
      for (int i = 0; i < NUM_RW; i++) v[i*DW +: DW] = rw_reset(i);
      return v;
   endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
   import sysctl_pkg::*;
#(
   parameter logic [31:0] CACHE_TYPE_VAL = 32'h0000_0000,
   parameter logic [31:0] CPU_ID_VAL     = 32'h0000_0000
) (
   input  sel_t        sel,
   output hit_t        hit,
   output logic [31:0] id_val
);

   logic        id_hit;
   logic [31:0] id_word;

   always_comb begin
      id_hit  = 1'b1;
      id_word = '0;
      if (sel.crn == 4'd0 && sel.op1 == 3'd0) begin
         case ({sel.crm, sel.op2})
            {4'd0, 3'd0}: id_word = 32'h410F_B024;
            {4'd0, 3'd1}: id_word = CACHE_TYPE_VAL;
            {4'd0, 3'd3}: id_word = 32'h0000_0800;
            {4'd0, 3'd5}: id_word = CPU_ID_VAL;
            {4'd1, 3'd0}: id_word = 32'h0000_0111;
            {4'd1, 3'd1}: id_word = 32'h0000_0001;
            {4'd1, 3'd2}: id_word = 32'h0000_0002;
            {4'd1, 3'd4}: id_word = 32'h0110_0103;
            {4'd1, 3'd5}: id_word = 32'h1002_0302;
            {4'd1, 3'd6}: id_word = 32'h0122_2000;
            {4'd1, 3'd7}: id_word = 32'h0000_0000;
            {4'd2, 3'd0}: id_word = 32'h0010_0011;
            {4'd2, 3'd1}: id_word = 32'h1200_2111;
            {4'd2, 3'd2}: id_word = 32'h1122_1011;
            {4'd2, 3'd3}: id_word = 32'h0110_2131;
            {4'd2, 3'd4}: id_word = 32'h0000_0141;
            default:      id_hit  = 1'b0;
         endcase
      end else begin
         id_hit = 1'b0;
      end
   end

   always_comb begin
      if (id_hit) begin
         hit = '{kind: K_ID, idx: '0, usr_rd: 1'b0, usr_wr: 1'b0};
      end else begin
         hit = lookup(sel);
      end
   end

   assign id_val = id_word;

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
   import sysctl_pkg::*;
#(
   parameter int                  NREG   = NUM_RW,
   parameter int                  WIDTH  = DW,
   parameter logic [NREG*WIDTH-1:0] RST_VEC = '0,
   localparam int                 IW     = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IW-1:0]    idx,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] rd_word
);

   if (NREG < 1) begin : g_bad_nreg
      $error("sysctl_store: NREG must be at least 1");
   end

   logic [WIDTH-1:0] q  [NREG];
   logic [NREG-1:0]  we;

   for (genvar i = 0; i < NREG; i++) begin : g_slot
      assign we[i] = wr_en && (idx == IW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q[i] <= RST_VEC[i*WIDTH +: WIDTH];
         else if (we[i]) q[i] <= wr_data;
      end

      // R3
      slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !we[i] |=> $stable(q[i]));

      // R3
      slot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         we[i] |=> q[i] == $past(wr_data));
   end

   always_comb begin
      rd_word = '0;
      if (int'(idx) < NREG) rd_word = q[idx];
   end

endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
   import sysctl_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_we,
   input  sel_t        sel,
   input  logic [31:0] wr_data
);

   sel_t        last_sel;
   logic [31:0] last_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_sel  <= '0;
         last_data <= '0;
      end else if (cmd_we) begin
         last_sel  <= sel;
         last_data <= wr_data;
      end
   end

   // R8
   cmd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we |=> (last_sel == $past(sel)) && (last_data == $past(wr_data)));

   // R7
   cmd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_we |=> $stable(last_sel) && $stable(last_data));

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
   import sysctl_pkg::*;
#(
   parameter logic [31:0] CACHE_TYPE_VAL = 32'h0000_0000,
   parameter logic [31:0] CPU_ID_VAL     = 32'h0000_0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        acc_rd,
   input  logic        acc_wr,
   input  logic [3:0]  sel_crn,
   input  logic [2:0]  sel_op1,
   input  logic [3:0]  sel_crm,
   input  logic [2:0]  sel_op2,
   input  logic [31:0] wr_data,
   input  logic        priv,
   output logic [31:0] rd_data,
   output logic        undef_acc
);

   if (DW != 32) begin : g_bad_width
      $error("sysctl_regbank: data width must be 32");
   end

   sel_t        sel;
   hit_t        hit;
   logic [31:0] id_val;
   logic [31:0] store_rd;
   logic        rd_ok, wr_ok, rw_we, cmd_we;

   assign sel = '{crn: sel_crn, op1: sel_op1, crm: sel_crm, op2: sel_op2};

   sysctl_decode #(
      .CACHE_TYPE_VAL (CACHE_TYPE_VAL),
      .CPU_ID_VAL     (CPU_ID_VAL)
   ) u_decode (
      .sel    (sel),
      .hit    (hit),
      .id_val (id_val)
   );

   assign rd_ok  = acc_rd && (hit.kind == K_ID || hit.kind == K_RW) && (priv || hit.usr_rd);
   assign wr_ok  = acc_wr && (hit.kind == K_RW || hit.kind == K_CMD) && (priv || hit.usr_wr);
   assign rw_we  = wr_ok && (hit.kind == K_RW);
   assign cmd_we = wr_ok && (hit.kind == K_CMD);

   sysctl_store #(
      .NREG    (NUM_RW),
      .WIDTH   (DW),
      .RST_VEC (rw_reset_vec())
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (rw_we),
      .idx     (hit.idx),
      .wr_data (wr_data),
      .rd_word (store_rd)
   );

   sysctl_cmd u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_we  (cmd_we),
      .sel     (sel),
      .wr_data (wr_data)
   );

   always_comb begin
      rd_data = '0;
      if (rd_ok) rd_data = (hit.kind == K_ID) ? id_val : store_rd;
   end

   assign undef_acc = (acc_rd && !rd_ok) || (acc_wr && !wr_ok);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_rd || acc_wr) |-> (rd_data == '0) && !undef_acc);

   // R4
   user_refuse_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && !priv && hit.kind == K_RW && !hit.usr_rd) |-> (rd_data == '0) && undef_acc);

   // R6
   uro_user_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && !priv && sel == mk(13,0,0,3)) |-> undef_acc && !rw_we);

   // R9
   unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((acc_rd || acc_wr) && hit.kind == K_NONE) |-> undef_acc && (rd_data == '0));

   // R2
   id_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && hit.kind == K_ID) |-> undef_acc && !rw_we && !cmd_we);

endmodule

// File: tb/sysctl_regbank_tb.sv
`timescale 1ns/1ps
module sysctl_regbank_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_rd = 1'b0, acc_wr = 1'b0, priv = 1'b0;
   logic [3:0]  sel_crn = '0, sel_crm = '0;
   logic [2:0]  sel_op1 = '0, sel_op2 = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        undef_acc;

   always #2.5 clk = ~clk;

   sysctl_regbank u_dut (
      .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
      .sel_crn(sel_crn), .sel_op1(sel_op1), .sel_crm(sel_crm), .sel_op2(sel_op2),
      .wr_data(wr_data), .priv(priv), .rd_data(rd_data), .undef_acc(undef_acc)
   );

   typedef struct {
      logic [31:0] exp_rd;
      logic        exp_u;
      string       tag;
   } item_t;

   item_t exp_q[$];
   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;

   task automatic acc(input logic rd, input logic wr, input int crn, input int op1,
                      input int crm, input int op2, input logic [31:0] d, input logic pv,
                      input logic [31:0] e_rd, input logic e_u, input string tag);
      item_t it;
      @(negedge clk);
      acc_rd  = rd;
      acc_wr  = wr;
      sel_crn = 4'(crn);
      sel_op1 = 3'(op1);
      sel_crm = 4'(crm);
      sel_op2 = 3'(op2);
      wr_data = d;
      priv    = pv;
      it.exp_rd = e_rd;
      it.exp_u  = e_u;
      it.tag    = tag;
      exp_q.push_back(it);
   endtask

   task automatic idle(input string tag);
      acc(1'b0, 1'b0, 0, 0, 0, 0, 32'h0, 1'b0, 32'h0, 1'b0, tag);
   endtask

   // monitor: compares one cycle's outputs 1 ns after the inputs settle
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            n_cmp++;
            if (rd_data !== it.exp_rd || undef_acc !== it.exp_u) begin
               n_bad++;
               $display("FAIL %s: rd_data=%h undef=%b expected rd_data=%h undef=%b",
                        it.tag, rd_data, undef_acc, it.exp_rd, it.exp_u);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: no strobe
      idle("R10 idle after reset");
      // R1: reset values
      acc(1,0, 1,0,0,0,  0, 1, 32'h0005_4078, 0, "R1 control reset");
      acc(1,0, 1,0,0,1,  0, 1, 32'h0000_000F, 0, "R1 aux reset");
      acc(1,0, 9,0,0,0,  0, 1, 32'hFFFF_FFF0, 0, "R1 dcache lockdown reset");
      acc(1,0, 10,0,2,0, 0, 1, 32'h0009_8AA4, 0, "R1 primary remap reset");
      acc(1,0, 10,0,2,1, 0, 1, 32'h44E0_48E0, 0, "R1 normal remap reset");
      acc(1,0, 2,0,0,0,  0, 1, 32'h0, 0, "R1 ttb0 reset");
      // R2: identification
      acc(1,0, 0,0,0,0,  0, 1, 32'h410F_B024, 0, "R2 main id");
      acc(1,0, 0,0,0,3,  0, 1, 32'h0000_0800, 0, "R2 tlb type");
      acc(1,0, 0,0,2,4,  0, 1, 32'h0000_0141, 0, "R2 isa word 4");
      acc(0,1, 0,0,0,0,  32'hFFFF_FFFF, 1, 32'h0, 1, "R2 id write refused");
      acc(1,0, 0,0,0,0,  0, 1, 32'h410F_B024, 0, "R2 main id kept");

      // R3: read and write in the same cycle
      acc(1,1, 1,0,0,0, 32'h1234_5678, 1, 32'h0005_4078, 0, "R3 same-cycle old value");
      acc(1,0, 1,0,0,0, 0, 1, 32'h1234_5678, 0, "R3 new value");

      // R4: user access to privileged register
      acc(1,0, 1,0,0,0, 0, 0, 32'h0, 1, "R4 user read refused");
      acc(0,1, 1,0,0,0, 32'h0000_DEAD, 0, 32'h0, 1, "R4 user write refused");
      acc(1,0, 1,0,0,0, 0, 1, 32'h1234_5678, 0, "R4 control unchanged");

      // R5: user thread register
      acc(0,1, 13,0,0,2, 32'h0000_A5A5, 0, 32'h0, 0, "R5 user write");
      acc(1,1, 13,0,0,2, 32'h0000_5A5A, 0, 32'h0000_A5A5, 0, "R5 user rd+wr");
      acc(1,0, 13,0,0,2, 0, 1, 32'h0000_5A5A, 0, "R5 privileged readback");

      // R6: user read-only thread register
      acc(1,1, 13,0,0,3, 32'h0000_1111, 0, 32'h0, 1, "R6 user rd ok, wr refused");
      acc(1,0, 13,0,0,3, 0, 0, 32'h0, 0, "R6 unchanged");
      acc(0,1, 13,0,0,3, 32'h0000_2222, 1, 32'h0, 0, "R6 privileged write");
      acc(1,0, 13,0,0,3, 0, 0, 32'h0000_2222, 0, "R6 user readback");

      // R7: barriers and prefetch flush
      acc(0,1, 7,0,10,4, 32'h1, 0, 32'h0, 0, "R7 sync barrier user");
      acc(0,1, 7,0,10,5, 32'h2, 0, 32'h0, 0, "R7 memory barrier user");
      acc(0,1, 7,0,5,4,  32'h3, 0, 32'h0, 0, "R7 prefetch flush user");
      acc(1,0, 7,0,10,4, 0, 1, 32'h0, 1, "R7 command read refused");

      // R8: cache and TLB commands
      acc(0,1, 8,0,7,0, 32'h4, 1, 32'h0, 0, "R8 tlb invalidate privileged");
      acc(0,1, 7,0,5,0, 32'h5, 1, 32'h0, 0, "R8 icache invalidate privileged");
      acc(0,1, 7,0,5,0, 32'h5, 0, 32'h0, 1, "R8 icache invalidate user refused");

      // R9: unmapped
      acc(1,0, 4,0,0,0, 0, 1, 32'h0, 1, "R9 unmapped read");
      acc(0,1, 1,1,0,0, 32'hFFFF_FFFF, 1, 32'h0, 1, "R9 unmapped write");
      acc(1,0, 1,0,0,0, 0, 1, 32'h1234_5678, 0, "R9 control unaffected");

      // R11: performance registers
      for (int k = 0; k < 4; k++)
         acc(0,1, 15,0,12,k, 32'hC0DE_0000 + 32'(k), 1, 32'h0, 0, "R11 perf write");
      for (int k = 0; k < 4; k++)
         acc(1,0, 15,0,12,k, 0, 1, 32'hC0DE_0000 + 32'(k), 0, "R11 perf readback");

      // R10: flag drops in idle cycle after a refused access
      acc(1,0, 4,0,0,0, 0, 1, 32'h0, 1, "R10 refused before idle");
      idle("R10 idle flag low");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule